// File: doc/BRIEF.md
# Per-Core Interrupt Mailbox Register File

This block is the interrupt-and-mailbox register set that sits beside one processor core. Software on any core reaches it through 32-bit reads and writes. It keeps a 32-bit pending word and a 32-bit enable mask. It also holds eight 32-bit message words that other cores can leave for this one. It drives one level-sensitive interrupt line into the core.

Pending bits are posted through a write-one-to-set command and retired through a write-one-to-clear command. Neither command keeps any state of its own. A separate `remote_set` input lets an inter-core sender post vectors directly, without taking a bus cycle.

The interrupt line is not a continuous function of pending AND enable. It is a flop that only set events can raise and only clear commands can lower:

- A set event raises the line when the resulting pending AND enable is nonzero.
- A clear command lowers the line only when pending ends at zero while the enable mask is nonzero.

Top module: `mbox_irq_regs`

## Requirements
- R1: After reset, pending, enable, every message word, `irq`, `err` and `rd_valid` are all zero.
- R2: Only `req_addr[7:0]` is decoded; higher address bits do not change which register is reached.
- R3: The pending word at offset 0x00 is read-only: a write there leaves it unchanged and pulses `err` for one cycle.
- R4: A write to offset 0x08 ORs the written value into pending, and `irq` becomes 1 when the new pending AND enable is nonzero (otherwise `irq` keeps its value).
- R5: A write to offset 0x0C clears the written bits from pending; `irq` becomes 0 only if pending is then zero and enable is nonzero, otherwise `irq` keeps its value.
- R6: Offsets 0x08 and 0x0C read as zero; offset 0x04 reads back the last value written to the enable mask.
- R7: Message word i (i = 0..7) is at offset 0x20 + 4*i and reads back the last value written to it.
- R8: An access to any other low-byte offset (including offsets that are not a multiple of 4) returns zero on a read, changes no state, and pulses `err` for one cycle.
- R9: A nonzero `remote_set` ORs into pending and raises `irq` under the same rule as R4; if it coincides with a bus write to 0x08, both values are ORed in together.
- R10: A write to the enable mask on its own never changes `irq`.
- R11: Read data with `rd_valid`, the `err` pulse, and all register and `irq` updates appear on the clock edge after the request or `remote_set` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address; low 8 bits decoded |
| req_wdata | input | DATA_W (32) | Write data |
| remote_set | input | DATA_W (32) | Vector bits posted by a remote sender |
| rd_data | output | DATA_W (32) | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| err | output | 1 | One-cycle pulse on a rejected access |
| irq | output | 1 | Level interrupt to the core |

## Verification
Two things can land on the pending word in the same cycle: a `remote_set` post and a bus set or clear command. The bench drives both together in one cycle. It judges the result by reading the pending word back and checking that both set values were merged. It also checks that `irq` rose when the merged value hit an enabled bit, and that a remote post with no enabled bit leaves a lowered line low.

// File: rtl/mbox_irq_regs.sv
module mbox_irq_regs #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] remote_set,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err,
  output logic              irq
);
  localparam int         IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;
  localparam logic [7:0] OFF_PEND  = 8'h00;
  localparam logic [7:0] OFF_MASK  = 8'h04;
  localparam logic [7:0] OFF_SET   = 8'h08;
  localparam logic [7:0] OFF_CLR   = 8'h0C;
  localparam logic [7:0] MBOX_BASE = 8'h20;
  localparam logic [7:0] MBOX_LAST = 8'(32 + 4 * (MBOX_WORDS - 1));

  logic [DATA_W-1:0] pend_q, mask_q;
  logic [DATA_W-1:0] mbox_q [MBOX_WORDS];

  wire [7:0] off = req_addr[7:0];
  wire [7:0] mrel = off - MBOX_BASE;
  wire [IDX_W-1:0] midx = mrel[IDX_W+1:2];

  wire hit_pend = off == OFF_PEND;
  wire hit_mask = off == OFF_MASK;
  wire hit_set  = off == OFF_SET;
  wire hit_clr  = off == OFF_CLR;
  wire hit_mbox = (off >= MBOX_BASE) && (off <= MBOX_LAST) && (off[1:0] == 2'b00);
  wire decoded  = hit_pend | hit_mask | hit_set | hit_clr | hit_mbox;

  wire wr = req_valid & req_write;
  wire rd = req_valid & ~req_write;

  wire               bus_set  = wr & hit_set;
  wire               bus_clr  = wr & hit_clr;
  wire               rem_evt  = |remote_set;
  wire [DATA_W-1:0]  set_bits = (bus_set ? req_wdata : '0) | remote_set;
  wire [DATA_W-1:0]  clr_bits = bus_clr ? req_wdata : '0;
  wire [DATA_W-1:0]  pend_d   = (pend_q & ~clr_bits) | set_bits;

  wire raise = (bus_set | rem_evt) && ((pend_d & mask_q) != '0);
  wire lower = bus_clr && (pend_d == '0) && (mask_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (wr && hit_mask) mask_q <= req_wdata;
      if (raise)      irq <= 1'b1;
      else if (lower) irq <= 1'b0;
    end
  end

  for (genvar g = 0; g < MBOX_WORDS; g++) begin : g_mbox
    always_ff @(posedge clk) begin
      if (!rst_n)                                     mbox_q[g] <= '0;
      else if (wr && hit_mbox && midx == IDX_W'(g))   mbox_q[g] <= req_wdata;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_pend)      rd_mux = pend_q;
    else if (hit_mask) rd_mux = mask_q;
    else if (hit_mbox) rd_mux = mbox_q[midx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= rd;
      rd_data  <= rd ? rd_mux : '0;
      err      <= req_valid & (~decoded | (req_write & hit_pend));
    end
  end
endmodule

module mbox_irq_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] remote_set,
  input logic              rd_valid,
  input logic              err,
  input logic              irq
);
  AST_IRQ_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(req_valid && req_write && req_addr[7:0] == 8'h08) || $past(remote_set != '0))); // R4
  AST_IRQ_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(req_valid && req_write && req_addr[7:0] == 8'h0C)); // R5
  AST_MASK_WRITE_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[7:0] == 8'h04 && remote_set == '0) |=> $stable(irq)); // R10
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write)); // R11
  AST_ERR_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid)); // R8
  AST_PEND_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[7:0] == 8'h00) |=> err); // R3
endmodule

bind mbox_irq_regs mbox_irq_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .remote_set(remote_set), .rd_valid(rd_valid),
  .err(err), .irq(irq));

// File: tb/sim_mbox_irq_regs.sv
`timescale 1ns/1ps
module sim_mbox_irq_regs;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, remote_set = '0;
  logic [31:0] rd_data;
  logic        rd_valid, err, irq;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mbox_irq_regs u0 (.clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
                    .remote_set, .rd_data, .rd_valid, .err, .irq);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R11 unexpected read response", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic acc(input logic v, input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic [31:0] rs, input logic exp_err, input string tag);
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; remote_set = rs;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; remote_set = '0;
    chk({tag, " err"}, {31'd0, err}, {31'd0, exp_err});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    acc(1'b1, 1'b1, a, d, '0, 1'b0, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag, input logic exp_err = 1'b0);
    exp_q.push_back(exp); tag_q.push_back(tag);
    acc(1'b1, 1'b0, a, '0, '0, exp_err, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    rst_n = 1'b1;
    rd(12'h000, 32'h0, "R1 pending");
    rd(12'h004, 32'h0, "R1 enable");
    rd(12'h03C, 32'h0, "R1 mbox7");

    wr(12'h004, 32'h0000_000F, "R6 write enable");
    rd(12'h004, 32'h0000_000F, "R6 enable readback");
    rd(12'h008, 32'h0, "R6 set port reads zero");
    rd(12'h00C, 32'h0, "R6 clear port reads zero");

    wr(12'h008, 32'h0000_0100, "R4 set masked bit");
    chk("R4 masked set keeps irq low", {31'd0, irq}, 32'd0);
    rd(12'h000, 32'h0000_0100, "R4 pending after set");
    wr(12'h008, 32'h0000_0001, "R4 set enabled bit");
    chk("R4 irq raised", {31'd0, irq}, 32'd1);

    acc(1'b1, 1'b1, 12'h000, 32'hFFFF_FFFF, '0, 1'b1, "R3 write to pending");
    rd(12'h000, 32'h0000_0101, "R3 pending unchanged");

    wr(12'h00C, 32'h0000_0001, "R5 partial clear");
    chk("R5 irq held while pending nonzero", {31'd0, irq}, 32'd1);
    wr(12'h00C, 32'h0000_0100, "R5 full clear");
    chk("R5 irq lowered", {31'd0, irq}, 32'd0);
    rd(12'h000, 32'h0, "R5 pending zero");

    wr(12'h004, 32'h0000_0001, "R10 enable bit0");
    wr(12'h008, 32'h0000_0001, "R4 set bit0");
    chk("R4 irq raised again", {31'd0, irq}, 32'd1);
    wr(12'h004, 32'h0, "R10 disable all");
    chk("R10 enable write keeps irq", {31'd0, irq}, 32'd1);
    wr(12'h00C, 32'h0000_0001, "R5 clear with enable zero");
    chk("R5 irq held when enable zero", {31'd0, irq}, 32'd1);
    wr(12'h004, 32'h0000_0001, "R10 re-enable");
    chk("R10 re-enable keeps irq", {31'd0, irq}, 32'd1);
    wr(12'h00C, 32'h0, "R5 empty clear");
    chk("R5 irq lowered by empty clear", {31'd0, irq}, 32'd0);

    wr(12'h324, 32'hCAFE_0001, "R2 aliased mbox1 write");
    rd(12'h024, 32'hCAFE_0001, "R2 R7 mbox1 readback");
    wr(12'h020, 32'h1111_2222, "R7 mbox0");
    wr(12'h02C, 32'h3333_4444, "R7 mbox3");
    wr(12'h03C, 32'h5555_6666, "R7 mbox7");
    rd(12'hF2C, 32'h3333_4444, "R2 R7 mbox3 aliased read");
    rd(12'h020, 32'h1111_2222, "R7 mbox0 readback");
    rd(12'h03C, 32'h5555_6666, "R7 mbox7 readback");

    rd(12'h010, 32'h0, "R8 undecoded read", 1'b1);
    acc(1'b1, 1'b1, 12'h040, 32'hDEAD_BEEF, '0, 1'b1, "R8 undecoded write");
    acc(1'b1, 1'b1, 12'h022, 32'hDEAD_BEEF, '0, 1'b1, "R8 misaligned write");
    rd(12'h020, 32'h1111_2222, "R8 mbox0 untouched");
    rd(12'h01C, 32'h0, "R8 gap read", 1'b1);

    wr(12'h004, 32'h0000_0003, "R9 enable bits 0-1");
    acc(1'b0, 1'b0, 12'h000, '0, 32'h0000_0002, 1'b0, "R9 remote post");
    chk("R9 remote raises irq", {31'd0, irq}, 32'd1);
    rd(12'h000, 32'h0000_0002, "R9 pending after remote");
    wr(12'h00C, 32'h0000_0002, "R9 clear");
    chk("R9 irq lowered", {31'd0, irq}, 32'd0);
    acc(1'b0, 1'b0, 12'h000, '0, 32'h0000_0010, 1'b0, "R9 remote masked post");
    chk("R9 masked remote keeps irq low", {31'd0, irq}, 32'd0);
    acc(1'b1, 1'b1, 12'h008, 32'h0000_0001, 32'h0000_0040, 1'b0, "R9 coincident set");
    chk("R9 coincident raises irq", {31'd0, irq}, 32'd1);
    rd(12'h000, 32'h0000_0051, "R9 coincident merge");
    acc(1'b1, 1'b1, 12'h00C, 32'h0000_0051, 32'h0000_0100, 1'b0, "R9 remote with clear");
    chk("R9 remote blocks lower", {31'd0, irq}, 32'd1);
    rd(12'h000, 32'h0000_0100, "R9 pending after clear plus remote");

    repeat (3) @(negedge clk);
    chk("R11 all reads answered", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule